// File: doc/BRIEF.md
# Hierarchical Display Interrupt Controller

This block collects hotplug events from the ports of a display engine and raises one level-sensitive interrupt line toward the CPU. It has two nested levels plus an optional third. The lowest level is a bank of four registers. One shows the live event levels. One masks events before they are latched. One holds the latched events, which software clears by writing ones. One selects which latched events may raise an interrupt. Above that bank sits a display control register, which has a global enable and a read-only summary flag. At the top sits an optional graphics control register with its own enable and summary flag. A configuration input selects whether the top level is part of the path.

Software reaches all registers through a plain 32-bit write/read port with byte addresses. Read data is combinational from the address. A write takes effect at the clock edge on which the write strobe is high. The event inputs are grouped into per-port fields. A port reports a hotplug only when every bit of its field is latched. The CPU line is registered, so it changes one cycle after the state that causes it. The reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `disp_irq_ctrl`

## Requirements
- R1: Offset 0x00 reads the current level of the event inputs in bits [NUM_EVT-1:0]. Writes to it have no effect.
- R2: A latched-event bit sets only on an edge where its event input is 1 and its mask bit (offset 0x04, 1 = blocked) is 0.
- R3: Writing offset 0x08 clears each latched bit written as 1 and leaves bits written as 0 unchanged. Writing back the value just read therefore clears exactly those bits.
- R4: If a latched bit is being set and cleared on the same edge, it ends up set.
- R5: Bit 23 of offset 0x10 is read-only and reads 1 exactly when some latched bit has its enable bit (offset 0x0C) set.
- R6: Bit 31 of offset 0x10 is a read/write display enable. With it at 0, the CPU line stays low.
- R7: When the top level is configured in (cfg_top_en = 1), offset 0x14 holds a read/write enable in bit 31 and a read-only display-pending flag in bit 16. The flag reads 1 when bit 31 and bit 23 of offset 0x10 are both 1. With bit 31 of 0x14 at 0, the CPU line stays low.
- R8: With cfg_top_en = 0, offset 0x14 reads zero and ignores writes, and the display level alone drives the CPU line.
- R9: port_hp[p] is 1 exactly when all FIELD_W latched bits [p*FIELD_W +: FIELD_W] are 1.
- R10: Any other offset, including ones not aligned to a word, reads zero and ignores writes.
- R11: After reset every register reads zero and cpu_irq is 0.
- R12: cpu_irq is registered. It rises or falls one clock edge after the latched state and enables that cause the change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_top_en | input | 1 | 1 = graphics control level is in the interrupt path |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 8 | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| hp_evt | input | NUM_EVT | Hotplug event input levels |
| port_hp | output | NUM_PORTS | Complete hotplug field latched, one bit per port |
| cpu_irq | output | 1 | Level interrupt to the CPU |

## Verification
Several properties are checked on every cycle after reset. Latched bits never rise without an unmasked event on the previous edge. An unmasked event always leaves its bit set, even when a clear is written at the same time. The CPU line equals the enabled-pending combination of the previous cycle. The line is never high without the display enable. Unmapped offsets always read zero. Other behaviour can only be shown by the bench's scenarios, because each needs a sequence of accesses: write-one-to-clear with mixed data, read-only bits resisting writes, the top-level bypass, whole-field port detection, and the state right after reset.

// File: rtl/disp_irq_pkg.sv
package disp_irq_pkg;

  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 8;

  // Register byte offsets
  localparam logic [ADDR_W-1:0] OFF_LIVE  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_BLOCK = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_LATCH = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_ALLOW = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_DCTL  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_GCTL  = 8'h14;

  // Control register bit positions
  localparam int unsigned DCTL_EN_BIT  = 31;
  localparam int unsigned DCTL_SUM_BIT = 23;
  localparam int unsigned GCTL_EN_BIT  = 31;
  localparam int unsigned GCTL_SUM_BIT = 16;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_LIVE,
    SEL_BLOCK,
    SEL_LATCH,
    SEL_ALLOW,
    SEL_DCTL,
    SEL_GCTL
  } reg_sel_e;

endpackage

// File: rtl/disp_irq_south.sv
module disp_irq_south #(
  parameter  int unsigned NUM_PORTS = 4,
  parameter  int unsigned FIELD_W   = 2,
  localparam int unsigned NUM_EVT   = NUM_PORTS * FIELD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_EVT-1:0]   evt_i,
  input  logic                 wr_block,
  input  logic                 wr_latch,
  input  logic                 wr_allow,
  input  logic [NUM_EVT-1:0]   wdata,
  output logic [NUM_EVT-1:0]   block_o,
  output logic [NUM_EVT-1:0]   latch_o,
  output logic [NUM_EVT-1:0]   allow_o,
  output logic                 pend_o,
  output logic [NUM_PORTS-1:0] port_hp_o
);

  logic [NUM_EVT-1:0] block_q, latch_q, allow_q;
  logic [NUM_EVT-1:0] latch_d, clr_vec, set_vec;

  // Next state of the latched events: clear first, then set, so a set wins
  always_comb begin
    clr_vec = wr_latch ? wdata : '0;
    set_vec = evt_i & ~block_q;
    latch_d = (latch_q & ~clr_vec) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      block_q <= '0;
      latch_q <= '0;
      allow_q <= '0;
    end else begin
      if (wr_block) block_q <= wdata;
      if (wr_allow) allow_q <= wdata;
      latch_q <= latch_d;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign port_hp_o[p] = &latch_q[p*FIELD_W +: FIELD_W];
  end

  assign pend_o  = |(latch_q & allow_q);
  assign block_o = block_q;
  assign latch_o = latch_q;
  assign allow_o = allow_q;

endmodule

// File: rtl/disp_irq_master.sv
module disp_irq_master (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_top_en,
  input  logic wr_dctl,
  input  logic wr_gctl,
  input  logic dctl_en_wdata,
  input  logic gctl_en_wdata,
  input  logic south_pend,
  output logic dctl_en_o,
  output logic gctl_en_o,
  output logic disp_pend_o,
  output logic irq_o
);

  logic dctl_en_q, gctl_en_q, irq_q;
  logic disp_pend, irq_d;

  always_comb begin
    disp_pend = dctl_en_q & south_pend;
    irq_d     = cfg_top_en ? (gctl_en_q & disp_pend) : disp_pend;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dctl_en_q <= 1'b0;
      gctl_en_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (wr_dctl) dctl_en_q <= dctl_en_wdata;
      if (wr_gctl) gctl_en_q <= gctl_en_wdata;
      irq_q <= irq_d;
    end
  end

  assign dctl_en_o   = dctl_en_q;
  assign gctl_en_o   = gctl_en_q;
  assign disp_pend_o = disp_pend;
  assign irq_o       = irq_q;

endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
  import disp_irq_pkg::*;
#(
  parameter  int unsigned NUM_PORTS = 4,
  parameter  int unsigned FIELD_W   = 2,
  localparam int unsigned NUM_EVT   = NUM_PORTS * FIELD_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_top_en,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic [NUM_EVT-1:0]   hp_evt,
  output logic [NUM_PORTS-1:0] port_hp,
  output logic                 cpu_irq
);

  // Reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // Address decode
  reg_sel_e sel;
  always_comb begin
    unique case (reg_addr)
      OFF_LIVE:  sel = SEL_LIVE;
      OFF_BLOCK: sel = SEL_BLOCK;
      OFF_LATCH: sel = SEL_LATCH;
      OFF_ALLOW: sel = SEL_ALLOW;
      OFF_DCTL:  sel = SEL_DCTL;
      OFF_GCTL:  sel = cfg_top_en ? SEL_GCTL : SEL_NONE;
      default:   sel = SEL_NONE;
    endcase
  end

  logic [NUM_EVT-1:0] block_w, latch_w, allow_w;
  logic               south_pend, dctl_en_w, gctl_en_w, disp_pend;
  logic               unused_wdata;

  assign unused_wdata = ^reg_wdata;

  disp_irq_south #(
    .NUM_PORTS (NUM_PORTS),
    .FIELD_W   (FIELD_W)
  ) u_south (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .evt_i     (hp_evt),
    .wr_block  (reg_wr && sel == SEL_BLOCK),
    .wr_latch  (reg_wr && sel == SEL_LATCH),
    .wr_allow  (reg_wr && sel == SEL_ALLOW),
    .wdata     (reg_wdata[NUM_EVT-1:0]),
    .block_o   (block_w),
    .latch_o   (latch_w),
    .allow_o   (allow_w),
    .pend_o    (south_pend),
    .port_hp_o (port_hp)
  );

  disp_irq_master u_master (
    .clk           (clk),
    .rst_n         (rst_sync_n),
    .cfg_top_en    (cfg_top_en),
    .wr_dctl       (reg_wr && sel == SEL_DCTL),
    .wr_gctl       (reg_wr && sel == SEL_GCTL),
    .dctl_en_wdata (reg_wdata[DCTL_EN_BIT]),
    .gctl_en_wdata (reg_wdata[GCTL_EN_BIT]),
    .south_pend    (south_pend),
    .dctl_en_o     (dctl_en_w),
    .gctl_en_o     (gctl_en_w),
    .disp_pend_o   (disp_pend),
    .irq_o         (cpu_irq)
  );

  // Read mux
  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_LIVE:  reg_rdata[NUM_EVT-1:0] = hp_evt;
      SEL_BLOCK: reg_rdata[NUM_EVT-1:0] = block_w;
      SEL_LATCH: reg_rdata[NUM_EVT-1:0] = latch_w;
      SEL_ALLOW: reg_rdata[NUM_EVT-1:0] = allow_w;
      SEL_DCTL: begin
        reg_rdata[DCTL_EN_BIT]  = dctl_en_w;
        reg_rdata[DCTL_SUM_BIT] = south_pend;
      end
      SEL_GCTL: begin
        reg_rdata[GCTL_EN_BIT]  = gctl_en_w;
        reg_rdata[GCTL_SUM_BIT] = disp_pend;
      end
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/disp_irq_chk.sv
module disp_irq_chk #(
  parameter int unsigned NUM_EVT = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cfg_top_en,
  input logic [7:0]         reg_addr,
  input logic [31:0]        reg_rdata,
  input logic [NUM_EVT-1:0] hp_evt,
  input logic [NUM_EVT-1:0] block_q,
  input logic [NUM_EVT-1:0] latch_q,
  input logic [NUM_EVT-1:0] allow_q,
  input logic               dctl_en,
  input logic               gctl_en,
  input logic               cpu_irq
);

  logic mapped;
  always_comb begin
    mapped = (reg_addr == 8'h00) || (reg_addr == 8'h04) || (reg_addr == 8'h08) ||
             (reg_addr == 8'h0C) || (reg_addr == 8'h10) ||
             (cfg_top_en && reg_addr == 8'h14);
  end

  AST_LATCH_ONLY_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
    ((latch_q & ~$past(latch_q)) & ~$past(hp_evt & ~block_q)) == '0);  // R2

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q & $past(hp_evt & ~block_q)) == $past(hp_evt & ~block_q));  // R4

  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq == $past(dctl_en && (|(latch_q & allow_q)) && (!cfg_top_en || gctl_en)));  // R12

  AST_IRQ_NEEDS_DISP_EN: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_irq |-> $past(dctl_en));  // R6

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |-> reg_rdata == 32'h0);  // R10

endmodule

bind disp_irq_ctrl disp_irq_chk #(.NUM_EVT(NUM_EVT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cfg_top_en (cfg_top_en),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .hp_evt     (hp_evt),
  .block_q    (block_w),
  .latch_q    (latch_w),
  .allow_q    (allow_w),
  .dctl_en    (dctl_en_w),
  .gctl_en    (gctl_en_w),
  .cpu_irq    (cpu_irq)
);

// File: tb/disp_irq_ctrl_test.sv
module disp_irq_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;
  localparam int FW = 2;
  localparam int NE = NP * FW;

  localparam logic [7:0] A_LIVE = 8'h00, A_BLOCK = 8'h04, A_LATCH = 8'h08,
                         A_ALLOW = 8'h0C, A_DCTL = 8'h10, A_GCTL = 8'h14;

  // {evt, mask, allow, disp_en, gfx_en, cfg_top}
  localparam int NVEC = 8;
  localparam logic [26:0] VEC [NVEC] = '{
    {8'h01, 8'h00, 8'h01, 1'b1, 1'b1, 1'b1},
    {8'h01, 8'h01, 8'h01, 1'b1, 1'b1, 1'b1},
    {8'hF0, 8'h30, 8'h80, 1'b1, 1'b1, 1'b1},
    {8'h0F, 8'h00, 8'hF0, 1'b1, 1'b1, 1'b1},
    {8'h03, 8'h00, 8'h03, 1'b0, 1'b1, 1'b1},
    {8'h03, 8'h00, 8'h03, 1'b1, 1'b0, 1'b1},
    {8'h03, 8'h00, 8'h03, 1'b1, 1'b0, 1'b0},
    {8'hAA, 8'h55, 8'hFF, 1'b0, 1'b1, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cfg_top_en = 1'b1;
  logic          reg_wr = 1'b0;
  logic [7:0]    reg_addr = 8'h00;
  logic [31:0]   reg_wdata = 32'h0;
  logic [31:0]   reg_rdata;
  logic [NE-1:0] hp_evt = '0;
  logic [NP-1:0] port_hp;
  logic          cpu_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_irq_ctrl #(.NUM_PORTS(NP), .FIELD_W(FW)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_top_en(cfg_top_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hp_evt(hp_evt), .port_hp(port_hp), .cpu_irq(cpu_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pulse(input logic [NE-1:0] v);
    @(negedge clk);
    hp_evt = v;
    @(negedge clk);
    hp_evt = '0;
  endtask

  task automatic setup(input logic [7:0] m, input logic [7:0] al, input logic de, input logic ge);
    wr(A_BLOCK, {24'h0, m});
    wr(A_ALLOW, {24'h0, al});
    wr(A_DCTL, {de, 31'h0});
    wr(A_GCTL, {ge, 31'h0});
    wr(A_LATCH, 32'hFFFF_FFFF);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R11: reset state
    rd(A_LIVE, r);  check("R11 live", r, 32'h0);
    rd(A_BLOCK, r); check("R11 mask", r, 32'h0);
    rd(A_LATCH, r); check("R11 latched", r, 32'h0);
    rd(A_ALLOW, r); check("R11 allow", r, 32'h0);
    rd(A_DCTL, r);  check("R11 dctl", r, 32'h0);
    rd(A_GCTL, r);  check("R11 gctl", r, 32'h0);
    check("R11 irq", {31'h0, cpu_irq}, 32'h0);

    // Vector table: R2 R5 R6 R7 R8
    for (int i = 0; i < NVEC; i++) begin
      logic [7:0] ev, mk, al, lat;
      logic de, ge, ct, sp, dp, ei;
      {ev, mk, al, de, ge, ct} = VEC[i];
      hp_evt = '0;
      cfg_top_en = ct;
      setup(mk, al, de, ge);
      pulse(ev);
      @(negedge clk);
      lat = ev & ~mk;
      sp  = |(lat & al);
      dp  = de & sp;
      ei  = ct ? (ge & dp) : dp;
      rd(A_LATCH, r); check("R2 latched", r, {24'h0, lat});
      rd(A_DCTL, r);  check("R5 R6 dctl", r, {de, 7'h0, sp, 23'h0});
      rd(A_GCTL, r);  check("R7 R8 gctl", r, ct ? {ge, 14'h0, dp, 16'h0} : 32'h0);
      check("R6 R7 R8 irq", {31'h0, cpu_irq}, {31'h0, ei});
    end

    cfg_top_en = 1'b1;
    setup(8'h00, 8'h00, 1'b0, 1'b0);

    // R1: live status, writes ignored
    @(negedge clk); hp_evt = 8'h5A;
    rd(A_LIVE, r); check("R1 live", r, 32'h5A);
    wr(A_LIVE, 32'hFFFF_FFFF);
    rd(A_LIVE, r); check("R1 write ignored", r, 32'h5A);
    hp_evt = '0;
    rd(A_LIVE, r); check("R1 live low", r, 32'h0);

    // R3: write-one-to-clear
    wr(A_LATCH, 32'hFFFF_FFFF);
    pulse(8'h0F);
    wr(A_LATCH, 32'h0);
    rd(A_LATCH, r); check("R3 zero write", r, 32'h0F);
    wr(A_LATCH, 32'h03);
    rd(A_LATCH, r); check("R3 partial clear", r, 32'h0C);
    wr(A_LATCH, r);
    rd(A_LATCH, r); check("R3 write back", r, 32'h0);

    // R4: set wins over clear
    @(negedge clk); hp_evt = 8'h01;
    wr(A_LATCH, 32'h01);
    rd(A_LATCH, r); check("R4 set wins", r, 32'h01);
    hp_evt = '0;
    wr(A_LATCH, 32'h01);
    rd(A_LATCH, r); check("R4 cleared", r, 32'h0);

    // R9: whole port field required
    pulse(8'h01);
    @(negedge clk); check("R9 half field", {28'h0, port_hp}, 32'h0);
    pulse(8'h02);
    @(negedge clk); check("R9 full field", {28'h0, port_hp}, 32'h1);
    pulse(8'hC0);
    @(negedge clk); check("R9 two ports", {28'h0, port_hp}, 32'h9);
    wr(A_LATCH, 32'hFF);

    // R10: unmapped offsets
    wr(8'h18, 32'hFFFF_FFFF);
    rd(8'h18, r); check("R10 unmapped", r, 32'h0);
    wr(8'h06, 32'hFFFF_FFFF);
    rd(8'h06, r); check("R10 unaligned", r, 32'h0);
    rd(A_BLOCK, r); check("R10 no alias", r, 32'h0);

    // R12: registered output latency (bypass path)
    cfg_top_en = 1'b0;
    setup(8'h00, 8'h01, 1'b1, 1'b0);
    pulse(8'h01);
    check("R12 irq not yet", {31'h0, cpu_irq}, 32'h0);
    @(negedge clk); check("R12 irq rises", {31'h0, cpu_irq}, 32'h1);
    wr(A_LATCH, 32'h01);
    check("R12 irq holds", {31'h0, cpu_irq}, 32'h1);
    @(negedge clk); check("R12 irq falls", {31'h0, cpu_irq}, 32'h0);

    // R7 R8: top level enable, acknowledge, bypass
    cfg_top_en = 1'b1;
    setup(8'h00, 8'h01, 1'b1, 1'b1);
    pulse(8'h01);
    rd(A_GCTL, r); check("R7 gctl pending", r, 32'h8001_0000);
    wr(A_GCTL, 32'h8001_0000);
    rd(A_GCTL, r); check("R7 ack keeps enable", r, 32'h8001_0000);
    check("R7 irq", {31'h0, cpu_irq}, 32'h1);
    wr(A_GCTL, 32'h0);
    rd(A_GCTL, r); check("R7 gctl disabled", r, 32'h0001_0000);
    @(negedge clk); check("R7 irq off", {31'h0, cpu_irq}, 32'h0);
    cfg_top_en = 1'b0;
    rd(A_GCTL, r); check("R8 gctl hidden", r, 32'h0);
    @(negedge clk); check("R8 bypass irq", {31'h0, cpu_irq}, 32'h1);
    wr(A_GCTL, 32'h8000_0000);
    cfg_top_en = 1'b1;
    rd(A_GCTL, r); check("R8 write ignored", r, 32'h0001_0000);

    // R5 R6: read-only summary, enable off
    rd(A_DCTL, r); check("R5 summary", r, 32'h8080_0000);
    wr(A_DCTL, 32'h0080_0000);
    rd(A_DCTL, r); check("R5 R6 summary ro", r, 32'h0080_0000);
    @(negedge clk); check("R6 irq off", {31'h0, cpu_irq}, 32'h0);
    wr(A_LATCH, 32'hFF);
    rd(A_DCTL, r); check("R5 cleared", r, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule